// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the two timing strobes a UART needs from one reference clock. One is a sample strobe that paces the receiver's oversampling. The other is a bit strobe that paces the transmitter. Each strobe is high for exactly one reference-clock cycle.

Software writes a configuration word through a single write strobe. The word holds five settings:
- a prescaler choice, divide by 1 or by 4;
- a 16-bit integer divisor;
- a 4-bit fraction counted in sixteenths;
- a two-bit sampling mode;
- (the write strobe itself restarts all counters).

The fraction lengthens some sample periods by one prescaled clock. It spreads those stretched periods evenly, so the average sample period is (integer + fraction/16) prescaled clocks. The bit rate is therefore reference / (prescaler × ratio × (integer + fraction/16)).

With a 64 MHz reference, prescaler 1 and divisor 1, the bit rate is 16, 8 or 4 Mbps for 4X, 8X or 16X sampling. With a 14.7456 MHz reference and 4X sampling, the fastest setting gives 3.6864 Mbps. An integer part of zero stops both strobes.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the stored integer divisor is zero, and both strobes stay low until a configuration is written.
- R2: With prescaler 1 and fraction 0, the sample strobe fires every I cycles for integer divisor I ≥ 1. The first strobe comes I cycles after the restart.
- R3: With `cfg_pre4`=1, every sample period is four times as long as with `cfg_pre4`=0. Counted from a restart, the k-th sample strobe lands in cycle 4·(k·I + ⌊k·F/16⌋).
- R4: With fraction F, the k-th sample strobe after a restart lands in cycle P·(k·I + ⌊k·F/16⌋), where P is 1 or 4. So F of every 16 sample periods are one prescaled clock longer, spread evenly.
- R5: `cfg_mode` selects the sampling ratio N: 2'b00 → 16, 2'b01 → 8, 2'b10 → 4, 2'b11 → 16. The bit strobe fires together with every N-th sample strobe after a restart, and never on its own.
- R6: While the stored integer divisor is zero, neither strobe fires, whatever the fraction, prescaler or mode.
- R7: A write restarts all counters. Cycle 0 is the cycle that follows the capturing edge. Both strobes are low in cycle 0, and later strobes follow R4 from cycle 0 with no partial period.
- R8: With prescaler 4, a sample strobe is never high in two consecutive cycles.
- R9: With I=1, F=0, prescaler 1 and 4X mode, the bit strobe fires every 4 reference cycles, which is the highest bit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe; captures settings and restarts counters |
| cfg_int | input | 16 | Integer part of divisor |
| cfg_frac | input | 4 | Fractional part of divisor, in sixteenths |
| cfg_pre4 | input | 1 | 1 selects divide-by-4 prescaler, 0 divide-by-1 |
| cfg_mode | input | 2 | Sampling ratio select (00:16X, 01:8X, 10:4X, 11:16X) |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe |

## Verification
A wrong fraction accumulator or divide counter moves a sample strobe by at least one cycle. Because the bench compares both strobes every cycle against the closed-form position P·(k·I + ⌊k·F/16⌋), such an error is reported at the first strobe it shifts, within one sample period.

A wrong oversampling count shows up at the first bit strobe after a restart, at the latest N sample strobes in. A restart that fails to clear state shows up as a strobe in cycle 0, or as a misplaced first strobe.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic              cfg_pre4,
  input  logic [1:0]        cfg_mode,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int CNT_W = INT_W + 1;
  localparam int OS_W  = 4;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              pre4_q;
  logic [1:0]        mode_q;
  logic [1:0]        pre_cnt;
  logic [CNT_W-1:0]  div_cnt;
  logic [FRAC_W-1:0] acc;
  logic [OS_W-1:0]   os_cnt;
  logic [OS_W-1:0]   os_top;

  wire active   = |int_q;
  wire pre_last = !pre4_q || (pre_cnt == 2'd3);
  wire [FRAC_W:0] acc_sum = {1'b0, acc} + {1'b0, frac_q};
  wire stretch  = acc_sum[FRAC_W];
  wire [CNT_W-1:0] period_m1 = {1'b0, int_q} - CNT_W'(1) + CNT_W'(stretch);
  wire s_fire   = active && pre_last && (div_cnt == period_m1);
  wire b_fire   = s_fire && (os_cnt == os_top);

  always_comb begin
    case (mode_q)
      2'b01:   os_top = OS_W'(7);
      2'b10:   os_top = OS_W'(3);
      default: os_top = OS_W'(15);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q       <= '0;
      frac_q      <= '0;
      pre4_q      <= 1'b0;
      mode_q      <= 2'b00;
      pre_cnt     <= '0;
      div_cnt     <= '0;
      acc         <= '0;
      os_cnt      <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else if (cfg_we) begin
      int_q       <= cfg_int;
      frac_q      <= cfg_frac;
      pre4_q      <= cfg_pre4;
      mode_q      <= cfg_mode;
      pre_cnt     <= '0;
      div_cnt     <= '0;
      acc         <= '0;
      os_cnt      <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      pre_cnt <= pre_last ? 2'd0 : pre_cnt + 2'd1;
      if (active && pre_last) begin
        if (s_fire) begin
          div_cnt <= '0;
          acc     <= acc_sum[FRAC_W-1:0];
          os_cnt  <= b_fire ? '0 : os_cnt + OS_W'(1);
        end else begin
          div_cnt <= div_cnt + CNT_W'(1);
        end
      end
      sample_tick <= s_fire;
      bit_tick    <= b_fire;
    end
  end

  assert_bit_with_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  assert_quiet_when_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0) |-> (!sample_tick && !bit_tick));

  assert_restart_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!sample_tick && !bit_tick));

  assert_pre4_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre4_q && sample_tick && !cfg_we) |=> !sample_tick);

  assert_bit_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !cfg_we) |=> !bit_tick);
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_int = '0;
  logic [3:0]  cfg_frac = '0;
  logic        cfg_pre4 = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        sample_tick, bit_tick;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  longint m_i, m_f, m_p, m_n, m_k, m_c;

  always #5 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_int(cfg_int),
    .cfg_frac(cfg_frac), .cfg_pre4(cfg_pre4), .cfg_mode(cfg_mode),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  function automatic longint ratio(input logic [1:0] m);
    case (m)
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 16;
    endcase
  endfunction

  function automatic longint target(input longint k);
    return m_p * (k * m_i + (k * m_f) / 16);
  endfunction

  task automatic compare_cycle(input string tag);
    logic es, eb;
    es = 1'b0;
    eb = 1'b0;
    if (m_i != 0 && m_c == target(m_k)) begin
      es = 1'b1;
      eb = (m_k % m_n) == 0;
      m_k++;
    end
    vectors++;
    if (sample_tick !== es || bit_tick !== eb) begin
      errors++;
      $display("FAIL %s cycle %0d: sample/bit actual %b%b expected %b%b",
               tag, m_c, sample_tick, bit_tick, es, eb);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      compare_cycle(tag);
      @(negedge clk);
      m_c++;
    end
  endtask

  task automatic apply(input int iv, input int fv, input bit p4, input logic [1:0] md);
    cfg_we   = 1'b1;
    cfg_int  = 16'(iv);
    cfg_frac = 4'(fv);
    cfg_pre4 = p4;
    cfg_mode = md;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_int  = 16'hFFFF;
    cfg_frac = 4'hF;
    m_i = iv; m_f = fv; m_p = p4 ? 4 : 1; m_n = ratio(md); m_k = 1; m_c = 0;
  endtask

  initial begin
    m_i = 0; m_f = 0; m_p = 1; m_n = 16; m_k = 1; m_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(40, "R1 reset idle");

    apply(3, 0, 1'b0, 2'b00);  run(200, "R2 R7 integer 16X");
    apply(2, 0, 1'b1, 2'b01);  run(300, "R3 R5 prescale4 8X");
    apply(1, 5, 1'b0, 2'b10);  run(300, "R4 fraction 4X");
    apply(2, 15, 1'b1, 2'b00); run(500, "R4 R3 R8 fraction prescale4");
    apply(1, 0, 1'b0, 2'b11);  run(100, "R5 mode 11 as 16X");
    apply(1, 0, 1'b0, 2'b10);  run(60,  "R9 max rate 4X");
    apply(5, 9, 1'b0, 2'b01);  run(37,  "R7 before mid-run write");
    apply(5, 9, 1'b0, 2'b01);  run(300, "R7 restart mid-period");
    apply(0, 7, 1'b1, 2'b10);  run(200, "R6 zero integer");
    apply(4, 3, 1'b1, 2'b10);  run(400, "R3 R4 R8 prescale4 frac 4X");
    apply(1, 0, 1'b0, 2'b00);  run(80,  "R2 divisor one");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule